// File: doc/BRIEF.md
# Chip-Select Framed Serial Command and Fault Readout Port

This block is the serial slave of a six-channel low-side switch controller. A host frames each transfer with an active-low chip select. While the frame is open, command bits arrive on the data input at each serial clock rising edge. In the same transfer, an 8-bit fault snapshot leaves on the serial data output. That snapshot is frozen at the moment the chip select falls. When the chip select returns high, the six newest command bits become the channel-enable register. The output enable of the serial data pin then drops, and a one-cycle pulse clears the fault register behind the port.

Every pin input is brought into the system clock domain through a synchronizer chain, and its edges are detected there. The shift path is as long as one frame, and output data changes on the serial clock falling edge. Several ports can therefore be chained: each one passes the host's bits on, delayed by one frame, after its own fault bits. The host then sends one byte per device, starting with the byte for the device farthest down the chain. A build parameter removes the under-voltage flag.

Top module: `lsw_serial_port`

## Requirements
- R1: After reset, chan_en_o is 0, sdo_oe_o is 0, sdo_o is 0, and neither flt_clr_o nor flt_refresh_o is asserted.
- R2: A falling chip select opens a frame. It asserts sdo_oe_o and gives exactly one flt_refresh_o pulse, in the same cycle that the fault snapshot is taken.
- R3: The snapshot is 8 bits, sent in this order: over-voltage (fault_live_i[7]), under-voltage (fault_live_i[6]), then the load flags of channels 5 down to 0 (fault_live_i[5:0]). A 1 means a fault is present.
- R4: Changes on fault_live_i after the falling chip select do not alter the frame in progress. The next frame reports the new values.
- R5: The first snapshot bit is on sdo_o as soon as the frame opens. Each serial clock rising edge samples sdi_i. Each serial clock falling edge moves the next bit onto sdo_o.
- R6: A rising chip select copies the six most recently shifted bits to chan_en_o. The newest bit goes to channel 0 and the sixth newest to channel 5, and a 1 turns a channel on. The same edge drops sdo_oe_o and gives exactly one flt_clr_o pulse. chan_en_o changes at no other time.
- R7: Once the snapshot has left, sdo_o repeats the bits taken from sdi_i, delayed by 8 bit times. In a two-device chain, the far device's output carries its own snapshot followed by the near device's snapshot.
- R8: Frames that are not 8 bits long still commit the last six bits in the shift path. If fewer than six bits were shifted, the low bits of the snapshot fill the upper part.
- R9: Serial clock edges while the chip select is high change neither the shift path nor chan_en_o, and produce no pulse.
- R10: With HAS_UV = 0, the under-voltage position of the snapshot always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select pin |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data in |
| fault_live_i | input | 8 | Live fault flags: [7] over-voltage, [6] under-voltage, [5:0] channel load faults |
| sdo_o | output | 1 | Serial data out value, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial data pad driver |
| chan_en_o | output | 6 | Channel-enable register |
| flt_clr_o | output | 1 | One-cycle pulse to clear and re-arm the fault register |
| flt_refresh_o | output | 1 | One-cycle strobe to refresh the fault flag |

## Verification
Some rules hold on every cycle, and the bound checker covers them. The enable register may only move in a commit cycle. A commit always closes the output enable, and a refresh always opens it. The output enable cannot rise without a refresh. The first bit on sdo_o always equals the over-voltage flag sampled at the capture edge. Other behaviour depends on whole frames, so only the bench scenarios show it: the bit order of the snapshot, blocking of mid-frame faults, the one-frame delay through a two-device chain, commits from short and long frames, serial clocks ignored while deselected, and the forced-zero under-voltage bit.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int CH_COUNT  = 6;
    localparam int FRAME_LEN = CH_COUNT + 2;

    // Snapshot word, MSB leaves first
    typedef struct packed {
        logic                ov;
        logic                uv;
        logic [CH_COUNT-1:0] load;
    } fault_word_t;

    typedef enum logic {
        PORT_IDLE   = 1'b0,
        PORT_ACTIVE = 1'b1
    } port_state_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic drive;
        logic commit;
    } port_ctl_t;

    function automatic fault_word_t pack_fault(input logic [FRAME_LEN-1:0] raw,
                                               input bit has_uv);
        fault_word_t w;
        w.ov   = raw[FRAME_LEN-1];
        w.uv   = has_uv ? raw[FRAME_LEN-2] : 1'b0;
        w.load = raw[CH_COUNT-1:0];
        return w;
    endfunction

endpackage

// File: rtl/lsw_sync_chain.sv
module lsw_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsw_port_ctrl.sv
module lsw_port_ctrl
    import lsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_lvl_i,
    input  logic      sclk_lvl_i,
    output port_ctl_t ctl_o,
    output logic      active_o
);
    port_state_e state_q, state_d;
    logic        cs_prev_q, sclk_prev_q;
    logic        cs_fall, cs_rise, sclk_rise, sclk_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            state_q     <= PORT_IDLE;
        end else begin
            cs_prev_q   <= cs_lvl_i;
            sclk_prev_q <= sclk_lvl_i;
            state_q     <= state_d;
        end
    end

    assign cs_fall   =  cs_prev_q & ~cs_lvl_i;
    assign cs_rise   = ~cs_prev_q &  cs_lvl_i;
    assign sclk_rise = ~sclk_prev_q &  sclk_lvl_i;
    assign sclk_fall =  sclk_prev_q & ~sclk_lvl_i;

    always_comb begin
        state_d = state_q;
        ctl_o   = '0;
        unique case (state_q)
            PORT_IDLE: begin
                if (cs_fall) begin
                    ctl_o.load = 1'b1;
                    state_d    = PORT_ACTIVE;
                end
            end
            PORT_ACTIVE: begin
                if (cs_rise) begin
                    ctl_o.commit = 1'b1;
                    state_d      = PORT_IDLE;
                end else begin
                    ctl_o.shift = sclk_rise;
                    ctl_o.drive = sclk_fall;
                end
            end
            default: state_d = PORT_IDLE;
        endcase
    end

    assign active_o = (state_q == PORT_ACTIVE);
endmodule

// File: rtl/lsw_shift_path.sv
module lsw_shift_path
    import lsw_pkg::*;
#(
    parameter int WIDTH   = FRAME_LEN,
    parameter int CMD_LSB = CH_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  port_ctl_t          ctl_i,
    input  logic [WIDTH-1:0]   load_word_i,
    input  logic               sdi_i,
    output logic [CMD_LSB-1:0] cmd_o,
    output logic               sdo_o
);
    logic [WIDTH-1:0] sh_q;
    logic             sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else if (ctl_i.load) begin
            sh_q  <= load_word_i;
            sdo_q <= load_word_i[WIDTH-1];
        end else begin
            if (ctl_i.shift) sh_q  <= {sh_q[WIDTH-2:0], sdi_i};
            if (ctl_i.drive) sdo_q <= sh_q[WIDTH-1];
        end
    end

    assign cmd_o = sh_q[CMD_LSB-1:0];
    assign sdo_o = sdo_q;
endmodule

// File: rtl/lsw_serial_port.sv
module lsw_serial_port
    import lsw_pkg::*;
#(
    parameter bit HAS_UV      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n_i,
    input  logic                 sclk_i,
    input  logic                 sdi_i,
    input  logic [FRAME_LEN-1:0] fault_live_i,
    output logic                 sdo_o,
    output logic                 sdo_oe_o,
    output logic [CH_COUNT-1:0]  chan_en_o,
    output logic                 flt_clr_o,
    output logic                 flt_refresh_o
);
    localparam int              NSIG     = 3;
    localparam int              IDX_CS   = 0;
    localparam int              IDX_SCLK = 1;
    localparam int              IDX_SDI  = 2;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b001;

    logic [NSIG-1:0]     pins, lvl;
    port_ctl_t           ctl;
    logic                active;
    fault_word_t         snap;
    logic [CH_COUNT-1:0] cmd_bits;
    logic                sdo_raw;
    logic [CH_COUNT-1:0] en_q;
    logic                clr_q, refresh_q;

    assign pins = {sdi_i, sclk_i, cs_n_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        lsw_sync_chain #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(IDLE_LVL[g])
        ) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pins[g]),
            .level_o(lvl[g])
        );
    end

    lsw_port_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_lvl_i  (lvl[IDX_CS]),
        .sclk_lvl_i(lvl[IDX_SCLK]),
        .ctl_o     (ctl),
        .active_o  (active)
    );

    assign snap = pack_fault(fault_live_i, HAS_UV);

    lsw_shift_path #(
        .WIDTH  (FRAME_LEN),
        .CMD_LSB(CH_COUNT)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .load_word_i(snap),
        .sdi_i      (lvl[IDX_SDI]),
        .cmd_o      (cmd_bits),
        .sdo_o      (sdo_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            clr_q     <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            clr_q     <= ctl.commit;
            refresh_q <= ctl.load;
            if (ctl.commit) en_q <= cmd_bits;
        end
    end

    assign chan_en_o     = en_q;
    assign flt_clr_o     = clr_q;
    assign flt_refresh_o = refresh_q;
    assign sdo_oe_o      = active;
    assign sdo_o         = sdo_raw & active;
endmodule

// File: rtl/lsw_serial_port_chk.sv
module lsw_serial_port_chk
    import lsw_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [FRAME_LEN-1:0] fault_live_i,
    input logic                 sdo_o,
    input logic                 sdo_oe_o,
    input logic [CH_COUNT-1:0]  chan_en_o,
    input logic                 flt_clr_o,
    input logic                 flt_refresh_o
);
    // R6: enable register moves only together with the commit pulse
    a_r6_en_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        (chan_en_o != $past(chan_en_o)) |-> flt_clr_o);

    // R6: commit closes the data output
    a_r6_clear_closes: assert property (@(posedge clk) disable iff (rst)
        flt_clr_o |-> !sdo_oe_o);

    // R2: refresh comes with an open output
    a_r2_refresh_opens: assert property (@(posedge clk) disable iff (rst)
        flt_refresh_o |-> sdo_oe_o);

    // R2: output never opens without a refresh
    a_r2_oe_rise_with_refresh: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe_o) |-> flt_refresh_o);

    // R5: first bit out is the over-voltage flag seen at capture
    a_r5_msb_first: assert property (@(posedge clk) disable iff (rst)
        flt_refresh_o |-> (sdo_o == $past(fault_live_i[FRAME_LEN-1])));

    // R1: idle pad value stays low
    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);

    // R2: the two pulses never coincide
    a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flt_clr_o && flt_refresh_o));
endmodule

bind lsw_serial_port lsw_serial_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fault_live_i (fault_live_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o),
    .chan_en_o    (chan_en_o),
    .flt_clr_o    (flt_clr_o),
    .flt_refresh_o(flt_refresh_o)
);

// File: tb/lsw_serial_port_bench.sv
module lsw_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [7:0] fault_up = '0, fault_dn = '0;
    logic       sdo_up, oe_up, clr_up, ref_up;
    logic       sdo_dn, oe_dn, clr_dn, ref_dn;
    logic [5:0] en_up, en_dn;
    int         n_chk = 0, n_bad = 0;
    int         clr_cnt = 0, ref_cnt = 0;
    localparam int HALF = 6;

    always #5 clk = ~clk;

    // near device (with under-voltage flag)
    lsw_serial_port #(.HAS_UV(1'b1)) u_lsw_serial_port (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .fault_live_i(fault_up), .sdo_o(sdo_up), .sdo_oe_o(oe_up),
        .chan_en_o(en_up), .flt_clr_o(clr_up), .flt_refresh_o(ref_up));

    // far device, no under-voltage flag, fed from the near one
    lsw_serial_port #(.HAS_UV(1'b0)) u_lsw_serial_port_dn (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdo_up),
        .fault_live_i(fault_dn), .sdo_o(sdo_dn), .sdo_oe_o(oe_dn),
        .chan_en_o(en_dn), .flt_clr_o(clr_dn), .flt_refresh_o(ref_dn));

    always @(negedge clk) begin
        if (!rst && clr_up) clr_cnt++;
        if (!rst && ref_up) ref_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of data MSB first, reads the chosen SDO before each rise
    task automatic run_frame(input int nbits, input logic [31:0] data, input bit from_dn,
                             input bit mid_en, input logic [7:0] mid_fault,
                             output logic [31:0] rd);
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        if (mid_en) fault_up = mid_fault;
        for (int i = 0; i < nbits; i++) begin
            sdi = data[nbits-1-i];
            idle(HALF);
            rd = {rd[30:0], (from_dn ? sdo_dn : sdo_up)};
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(HALF);
    endtask

    // {fault_up[7:0], cmd[7:0], expected readout[7:0], expected enables[5:0]}
    localparam logic [29:0] VEC [6] = '{
        {8'h00, 8'h3F, 8'h00, 6'h3F},
        {8'hA5, 8'h15, 8'hA5, 6'h15},
        {8'h5A, 8'hC2, 8'h5A, 6'h02},
        {8'hFF, 8'h00, 8'hFF, 6'h00},
        {8'h81, 8'hE9, 8'h81, 6'h29},
        {8'h40, 8'h2A, 8'h40, 6'h2A}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          c0, r0;
        idle(4);
        rst = 1'b0;
        idle(4);

        // R1 reset state
        chk("R1 chan_en", en_up, 0);
        chk("R1 oe", oe_up, 0);
        chk("R1 sdo", sdo_up, 0);
        chk("R1 pulses", {clr_cnt[7:0], ref_cnt[7:0]}, 0);

        // R2 output opens and refresh fires once
        @(negedge clk);
        fault_up = 8'h3C;
        cs_n = 1'b0;
        idle(HALF);
        chk("R2 oe open", oe_up, 1);
        chk("R2 one refresh", ref_cnt, 1);
        chk("R5 first bit is ov", sdo_up, 0);
        cs_n = 1'b1;
        idle(HALF);

        // table of frames: R3 ordering, R5 timing, R6 commit
        for (int v = 0; v < 6; v++) begin
            fault_up = VEC[v][29:22];
            c0 = clr_cnt;
            r0 = ref_cnt;
            run_frame(8, {24'h0, VEC[v][21:14]}, 1'b0, 1'b0, 8'h00, rd);
            chk("R3 R5 readout", rd[7:0], VEC[v][13:6]);
            chk("R6 enables", en_up, VEC[v][5:0]);
            chk("R6 oe closed", oe_up, 0);
            chk("R6 one clear", clr_cnt - c0, 1);
            chk("R2 one refresh per frame", ref_cnt - r0, 1);
        end

        // R4 mid-frame fault change is not captured
        fault_up = 8'h12;
        run_frame(8, 32'h05, 1'b0, 1'b1, 8'hED, rd);
        chk("R4 frozen snapshot", rd[7:0], 8'h12);
        run_frame(8, 32'h05, 1'b0, 1'b0, 8'h00, rd);
        chk("R4 next frame new value", rd[7:0], 8'hED);

        // R7 two-device chain, R10 far device hides under-voltage
        fault_up = 8'h4B;
        fault_dn = 8'hC6;
        run_frame(16, {16'h0, 8'h2D, 8'h33}, 1'b1, 1'b0, 8'h00, rd);
        chk("R7 R10 far snapshot then near", rd[15:0], {8'h86, 8'h4B});
        chk("R7 near enables", en_up, 6'h33);
        chk("R7 far enables", en_dn, 6'h2D);
        run_frame(16, {16'h0, 8'h00, 8'h00}, 1'b0, 1'b0, 8'h00, rd);
        chk("R7 near passes data after snapshot", rd[15:0], {8'h4B, 8'h00});

        // R8 long and short frames
        fault_up = 8'h00;
        run_frame(10, 32'h35A, 1'b0, 1'b0, 8'h00, rd);
        chk("R8 ten-bit frame", en_up, 6'h1A);
        fault_up = 8'hC6;
        run_frame(3, 32'h5, 1'b0, 1'b0, 8'h00, rd);
        chk("R8 three-bit frame", en_up, 6'h35);

        // R9 clocks while deselected
        fault_up = 8'h21;
        c0 = clr_cnt;
        r0 = ref_cnt;
        sdi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
            idle(HALF);
        end
        chk("R9 enables held", en_up, 6'h35);
        chk("R9 no pulses", {clr_cnt - c0, ref_cnt - r0}, 0);
        chk("R9 oe low", oe_up, 0);
        run_frame(8, 32'h00, 1'b0, 1'b0, 8'h00, rd);
        chk("R9 readout intact", rd[7:0], 8'h21);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule